// File: doc/BRIEF.md
# HDB3 Line Code Violation Monitor

This block watches a received E1 bipolar line, delivered as two rails that are sampled on the rising edge of the recovered bit clock. For every bipolar violation (a mark with the same polarity as the mark before it), the monitor decides whether the violation is part of a legal HDB3 zero substitution or a real coding error. Optionally, under a mode input, it also treats a long run of zeros as an error.

Each qualifying bit advances a 16-bit saturating error counter by one. A synchronous clear returns the counter to zero. A host reads the count as two bytes. Reading the upper byte freezes a copy of the lower byte, so that the two bytes form one coherent value even when the counter moves between the two accesses.

Top module: `hdb3_lcv_monitor`

## Requirements
- R1: After reset, both bytes read as zero. The previous-mark polarity and the previous-violation polarity are unknown. The three bits before reset count as unknown, so they can never complete a substitution pattern.
- R2: In one bit, pos_i alone is a positive mark, neg_i alone is a negative mark, and neither rail high is a zero. A mark whose polarity is opposite to the previous mark is a normal mark and is never counted.
- R3: When pos_i and neg_i are both high in one bit, that bit is counted. It leaves both polarity trackers unchanged, it ends any zero run, and it can never serve as the leading mark of a substitution pattern.
- R4: A mark with the same polarity as the previous mark is a violation. It goes uncounted only when all three conditions hold: the two bits just before it were zeros, the bit before those was a zero or a normal mark, and its polarity is opposite to the previous violation. Any other violation is counted.
- R5: The first mark after reset and the first violation after reset are never counted. Every violation, counted or not, becomes the new previous-violation polarity.
- R6: When exz_mode_i is low, zero runs are never counted. When it is high, the fourth consecutive zero adds one count, and further zeros in the same run add nothing.
- R7: A bit sampled at a clock edge changes the count at that same edge. The count changes by at most one per bit.
- R8: The count stops at 0xFFFF and does not wrap.
- R9: clear_i high at an edge sets the count to zero, and it takes priority over an increment in the same bit.
- R10: hi_byte_o always shows count bits 15..8. rd_hi_i high at an edge copies count bits 7..0, as they stood before that edge, into lo_byte_o. The copy is held until the next rd_hi_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_i | input | 1 | Positive rail, high for a positive mark |
| neg_i | input | 1 | Negative rail, high for a negative mark |
| exz_mode_i | input | 1 | High to also count runs of four zeros |
| clear_i | input | 1 | Synchronous clear of the error count |
| rd_hi_i | input | 1 | Strobe marking a host read of the upper byte |
| hi_byte_o | output | 8 | Upper byte of the error count |
| lo_byte_o | output | 8 | Lower byte held at the last upper-byte read |

## Verification
A line bit, clear or increment takes effect on the count at the same rising edge that samples it. hi_byte_o therefore reflects that edge at once, while lo_byte_o reflects the count from just before the edge at which rd_hi_i was high. The bench changes inputs on the falling edge and compares both bytes against its behavioural model on the next falling edge, half a period after the edge that is due to act. For a host read, the bench takes hi_byte_o in the strobe cycle before the edge and lo_byte_o after it, so each read checks coherence directly, including a read that lands on a carry from 0x00FF to 0x0100.

// File: rtl/hdb3_mon_pkg.sv
package hdb3_mon_pkg;

    typedef enum logic [1:0] {
        BK_ZERO = 2'd0,
        BK_MARK = 2'd1,
        BK_VIOL = 2'd2
    } bit_kind_e;

    typedef struct packed {
        logic known;
        logic negative;
    } polarity_t;

    typedef struct packed {
        logic dual_rail;
        logic bad_bipolar;
        logic long_zero;
    } lcv_event_t;

    // bits of history needed ahead of a substitution violation
    localparam int SUB_HIST = 3;

    // b1 is the most recent bit before the candidate violation
    function automatic logic sub_prefix_ok(bit_kind_e b1, bit_kind_e b2, bit_kind_e b3);
        return (b1 == BK_ZERO) && (b2 == BK_ZERO) &&
               ((b3 == BK_ZERO) || (b3 == BK_MARK));
    endfunction

    function automatic logic any_event(lcv_event_t e);
        return e.dual_rail | e.bad_bipolar | e.long_zero;
    endfunction

endpackage

// File: rtl/hdb3_bipolar_classifier.sv
module hdb3_bipolar_classifier
    import hdb3_mon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pos_i,
    input  logic neg_i,
    output logic dual_rail_o,
    output logic bad_bv_o,
    output logic zero_bit_o
);

    polarity_t last_mark_q;
    polarity_t last_viol_q;
    bit_kind_e hist_q [SUB_HIST];
    bit_kind_e cur_kind;
    logic      single_mark;
    logic      is_bv;
    logic      substitution;

    always_comb begin
        single_mark  = pos_i ^ neg_i;
        dual_rail_o  = pos_i & neg_i;
        zero_bit_o   = ~(pos_i | neg_i);
        is_bv        = single_mark && last_mark_q.known &&
                       (last_mark_q.negative == neg_i);
        substitution = sub_prefix_ok(hist_q[0], hist_q[1], hist_q[2]) &&
                       (last_viol_q.negative != neg_i);
        bad_bv_o     = is_bv && last_viol_q.known && !substitution;
        if (dual_rail_o || is_bv) begin
            cur_kind = BK_VIOL;
        end else if (single_mark) begin
            cur_kind = BK_MARK;
        end else begin
            cur_kind = BK_ZERO;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_mark_q <= '0;
            last_viol_q <= '0;
        end else begin
            if (single_mark) begin
                last_mark_q <= '{known: 1'b1, negative: neg_i};
            end
            if (is_bv) begin
                last_viol_q <= '{known: 1'b1, negative: neg_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q[0] <= BK_VIOL;
        end else begin
            hist_q[0] <= cur_kind;
        end
    end

    for (genvar g = 1; g < SUB_HIST; g++) begin : g_hist
        always_ff @(posedge clk) begin
            if (rst) begin
                hist_q[g] <= BK_VIOL;
            end else begin
                hist_q[g] <= hist_q[g-1];
            end
        end
    end

endmodule

// File: rtl/hdb3_zero_run.sv
module hdb3_zero_run #(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic zero_bit_i,
    output logic run_hit_o
);

    localparam int RW = $clog2(RUN_LEN + 1);
    localparam logic [RW-1:0] HIT_AT = RW'(RUN_LEN - 1);
    localparam logic [RW-1:0] TOP    = RW'(RUN_LEN);

    logic [RW-1:0] run_q;

    assign run_hit_o = zero_bit_i && (run_q == HIT_AT);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (!zero_bit_i) begin
            run_q <= '0;
        end else if (run_q != TOP) begin
            run_q <= run_q + 1'b1;
        end
    end

endmodule

// File: rtl/lcv_sat_counter.sv
module lcv_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] MAXV = '1;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            count_o <= '0;
        end else if (inc_i && count_o != MAXV) begin
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/lcv_byte_reader.sv
module lcv_byte_reader #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_hi_i,
    input  logic [2*BYTE_W-1:0]   count_i,
    output logic [BYTE_W-1:0]     hi_o,
    output logic [BYTE_W-1:0]     lo_o
);

    assign hi_o = count_i[2*BYTE_W-1:BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_o <= '0;
        end else if (rd_hi_i) begin
            lo_o <= count_i[BYTE_W-1:0];
        end
    end

endmodule

// File: rtl/hdb3_lcv_monitor.sv
module hdb3_lcv_monitor
    import hdb3_mon_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int RUN_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pos_i,
    input  logic              neg_i,
    input  logic              exz_mode_i,
    input  logic              clear_i,
    input  logic              rd_hi_i,
    output logic [BYTE_W-1:0] hi_byte_o,
    output logic [BYTE_W-1:0] lo_byte_o
);

    localparam int CNT_W = 2 * BYTE_W;

    logic             dual_rail;
    logic             bad_bv;
    logic             zero_bit;
    logic             run_hit;
    lcv_event_t       evt;
    logic [CNT_W-1:0] count_q;

    hdb3_bipolar_classifier u_class (
        .clk         (clk),
        .rst         (rst),
        .pos_i       (pos_i),
        .neg_i       (neg_i),
        .dual_rail_o (dual_rail),
        .bad_bv_o    (bad_bv),
        .zero_bit_o  (zero_bit)
    );

    hdb3_zero_run #(.RUN_LEN(RUN_LEN)) u_zrun (
        .clk        (clk),
        .rst        (rst),
        .zero_bit_i (zero_bit),
        .run_hit_o  (run_hit)
    );

    always_comb begin
        evt.dual_rail   = dual_rail;
        evt.bad_bipolar = bad_bv;
        evt.long_zero   = run_hit & exz_mode_i;
    end

    lcv_sat_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clear_i),
        .inc_i   (any_event(evt)),
        .count_o (count_q)
    );

    lcv_byte_reader #(.BYTE_W(BYTE_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_hi_i (rd_hi_i),
        .count_i (count_q),
        .hi_o    (hi_byte_o),
        .lo_o    (lo_byte_o)
    );

endmodule

// File: rtl/hdb3_lcv_monitor_chk.sv
module hdb3_lcv_monitor_chk #(
    parameter int BYTE_W = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  pos_i,
    input logic                  neg_i,
    input logic                  exz_mode_i,
    input logic                  clear_i,
    input logic                  rd_hi_i,
    input logic [2*BYTE_W-1:0]   count_q,
    input logic [BYTE_W-1:0]     lo_byte_o
);

    localparam int CNT_W = 2 * BYTE_W;
    localparam logic [CNT_W-1:0] MAXV = '1;

    assert_step_max_one_R7: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (count_q == '0));

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (!clear_i && count_q == MAXV) |=> (count_q == MAXV));

    assert_dual_rail_count_R3: assert property (@(posedge clk) disable iff (rst)
        (pos_i && neg_i && !clear_i && count_q != MAXV) |=> (count_q == $past(count_q) + 1'b1));

    assert_low_capture_R10: assert property (@(posedge clk) disable iff (rst)
        rd_hi_i |=> (lo_byte_o == $past(count_q[BYTE_W-1:0])));

    assert_quiet_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (!pos_i && !neg_i && !exz_mode_i && !clear_i) |=> $stable(count_q));

endmodule

bind hdb3_lcv_monitor hdb3_lcv_monitor_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pos_i      (pos_i),
    .neg_i      (neg_i),
    .exz_mode_i (exz_mode_i),
    .clear_i    (clear_i),
    .rd_hi_i    (rd_hi_i),
    .count_q    (count_q),
    .lo_byte_o  (lo_byte_o)
);

// File: tb/hdb3_lcv_monitor_tb.sv
module hdb3_lcv_monitor_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pos_i = 1'b0;
    logic       neg_i = 1'b0;
    logic       exz_mode_i = 1'b0;
    logic       clear_i = 1'b0;
    logic       rd_hi_i = 1'b0;
    logic [7:0] hi_byte_o;
    logic [7:0] lo_byte_o;

    always #5 clk = ~clk;

    hdb3_lcv_monitor u_dut (
        .clk        (clk),
        .rst        (rst),
        .pos_i      (pos_i),
        .neg_i      (neg_i),
        .exz_mode_i (exz_mode_i),
        .clear_i    (clear_i),
        .rd_hi_i    (rd_hi_i),
        .hi_byte_o  (hi_byte_o),
        .lo_byte_o  (lo_byte_o)
    );

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [7:0] last_hi;

    // behavioural model: -1 = unknown polarity, 0 = positive, 1 = negative
    // history kinds: 0 zero, 1 normal mark, 2 violation/unknown; index 0 newest
    int m_pm = -1;
    int m_pv = -1;
    int m_zrun = 0;
    int m_cnt = 0;
    int m_hold = 0;
    int m_hist[$] = '{2, 2, 2};

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_bit(bit p, bit n, bit mode, bit clr, bit rd);
        int kind;
        int pol;
        bit inc;
        inc = 1'b0;
        if (rd) m_hold = m_cnt & 255;
        if (p && n) begin
            kind = 2; inc = 1'b1; m_zrun = 0;
        end else if (p || n) begin
            pol = n ? 1 : 0;
            m_zrun = 0;
            if (m_pm < 0 || pol != m_pm) begin
                kind = 1; m_pm = pol;
            end else begin
                kind = 2;
                if (m_pv >= 0) begin
                    if (!(m_hist[0] == 0 && m_hist[1] == 0 && m_hist[2] != 2) || pol == m_pv)
                        inc = 1'b1;
                end
                m_pv = pol;
            end
        end else begin
            kind = 0;
            m_zrun++;
            if (m_zrun == 4 && mode) inc = 1'b1;
        end
        m_hist.push_front(kind);
        void'(m_hist.pop_back());
        if (clr) m_cnt = 0;
        else if (inc && m_cnt < 65535) m_cnt++;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(bit p, bit n, bit mode, bit clr, bit rd);
        pos_i = p; neg_i = n; exz_mode_i = mode; clear_i = clr; rd_hi_i = rd;
        #1 last_hi = hi_byte_o;
        @(posedge clk);
        model_bit(p, n, mode, clr, rd);
        @(negedge clk);
        check("R7 upper byte against model", int'(hi_byte_o), m_cnt >> 8);
        check("R10 held lower byte against model", int'(lo_byte_o), m_hold);
    endtask

    task automatic zeros(int k, bit mode);
        for (int i = 0; i < k; i++) step(1'b0, 1'b0, mode, 1'b0, 1'b0);
    endtask

    task automatic duals(int k);
        for (int i = 0; i < k; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    // host read of both bytes while the line carries bit (p,n)
    task automatic read_chk(bit p, bit n, bit mode, int exp, string tag);
        step(p, n, mode, 1'b0, 1'b1);
        check(tag, {16'd0, last_hi, lo_byte_o}, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 upper byte after reset", int'(hi_byte_o), 0);
        check("R1 lower byte after reset", int'(lo_byte_o), 0);

        // P N 0 0 0 N(first violation) P 0 0 P(B00V, legal)
        step(1,0,0,0,0); step(0,1,0,0,0); zeros(3, 0); step(0,1,0,0,0);
        step(1,0,0,0,0); zeros(2, 0); step(1,0,0,0,0);
        read_chk(0, 0, 0, 0, "R5 first violation free, R4 legal substitution");
        // 0 0 P: 000V with same polarity as previous violation -> counted
        zeros(2, 0); step(1,0,0,0,0);
        read_chk(0, 1, 0, 1, "R4 repeated violation polarity counted");
        // after N: 0 0 N legal B00V, then alternating marks
        zeros(2, 0); step(0,1,0,0,0);
        step(1,0,0,0,0); step(0,1,0,0,0); step(1,0,0,0,0);
        read_chk(0, 1, 0, 1, "R2 alternating marks not counted");
        // N after N with no zeros -> counted; dual rail -> counted
        step(0,1,0,0,0);
        step(1,1,0,0,0);
        read_chk(1, 0, 0, 3, "R3 dual rail counted, polarity kept");
        // zero runs
        zeros(6, 0);
        read_chk(0, 1, 0, 3, "R6 zero run ignored in low mode");
        zeros(8, 1);
        read_chk(1, 0, 1, 4, "R6 long run counted once");
        zeros(3, 1);
        read_chk(0, 1, 1, 4, "R6 three zeros not counted");
        // clear wins over a dual-rail bit
        step(1,1,0,1,0);
        read_chk(1, 0, 0, 0, "R9 clear priority");
        // coherent read across a carry
        duals(255);
        read_chk(1, 1, 0, 255, "R10 read coherent at carry");
        read_chk(0, 1, 0, 256, "R10 read after carry");
        // saturation
        duals(65540);
        read_chk(1, 0, 0, 65535, "R8 saturation");
        step(0,0,0,1,0);
        read_chk(0, 1, 0, 0, "R9 clear from saturation");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule